// File: doc/BRIEF.md
# DRAM Initialization and Refresh Scheduler

This block tells a DRAM controller when it has to run wake-up cycles and when it has to run refresh cycles. It first counts out a power-up pause in clock cycles. It then asks for a fixed burst of wake-up cycles. Each of these is a refresh-type RAS cycle, either RAS-only or CAS-before-RAS. After the burst it asks for refresh cycles at a steady rate. The rate is one cycle every retention period divided by the row count, so that every row is refreshed before its data decays.

Each refresh cycle is passed to the controller through a request/acknowledge handshake. While the controller is busy, owed refreshes are held in a small backlog counter with a fixed limit, and an urgency flag is raised once two or more are owed. An inactivity watchdog runs alongside. If no RAS cycle completes for a whole retention period, the block drops its ready flag and asks for the wake-up burst again. Generating the strobes themselves is the controller's job.

Top module: `dram_refresh_sched`

## Requirements
- R1: While rst_ni is low, and in the cycle after it is released, ready_o, init_o, ref_req_o and urgent_o are 0 and pending_o is 0.
- R2: For the first PAUSE_US*CLK_MHZ clock edges after reset, ref_req_o, init_o and ready_o stay 0. init_o rises after exactly that many edges. ras_cycle_i and ref_ack_i have no effect during the pause.
- R3: After the pause, init_o and ref_req_o are both 1 until INIT_CYCLES acknowledges have been accepted. An acknowledge is accepted only in a cycle where ref_req_o is 1. ready_o is 0 for the whole burst.
- R4: ready_o rises, and init_o falls, in the cycle after the edge that accepts the last wake-up acknowledge.
- R5: While ready_o is 1, one refresh is added to the owed count every REFRESH_CLKS = floor(RETENTION_US*CLK_MHZ/ROWS) clock edges. The first is added REFRESH_CLKS edges after ready_o rises.
- R6: While ready_o is 1, ref_req_o is 1 exactly when pending_o is non-zero. Each accepted acknowledge lowers pending_o by one. An acknowledge given while ref_req_o is 0 changes nothing.
- R7: pending_o never exceeds MAX_BACKLOG. A refresh that falls due while the count is already at the limit is not added.
- R8: urgent_o is 1 exactly when ready_o is 1 and pending_o is 2 or more.
- R9: If no RAS activity happens for WDOG_CLKS = RETENTION_US*CLK_MHZ consecutive clock edges while ready_o is 1, ready_o falls after the last of those edges. RAS activity means an ras_cycle_i pulse or an accepted acknowledge. When ready_o falls, pending_o goes to 0 and a new burst of INIT_CYCLES wake-up requests starts, as in R3 and R4.
- R10: An ras_cycle_i pulse restarts the watchdog, so pulses spaced less than WDOG_CLKS apart keep ready_o high even when no refresh is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; CLK_MHZ edges per microsecond |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_cycle_i | input | 1 | One-cycle pulse per RAS cycle the controller completes |
| ref_ack_i | input | 1 | Controller has run the requested refresh cycle |
| ref_req_o | output | 1 | A refresh or wake-up cycle is requested |
| init_o | output | 1 | The current request is part of a wake-up burst |
| ready_o | output | 1 | The device may be used for normal accesses |
| urgent_o | output | 1 | Two or more refreshes are owed |
| pending_o | output | $clog2(MAX_BACKLOG+1) | Number of refreshes owed |

## Verification
The scheduler is driven in four patterns. Prompt acknowledges show the refresh spacing and its rounding. A stalled controller that keeps the watchdog alive with RAS pulses fills the backlog to its cap and shows urgency. Acknowledges given with no request outstanding show they are ignored. A fully idle controller trips the watchdog, which must count its window exactly and then repeat the burst. Stray acknowledges and RAS pulses during the pause and between burst acknowledges separate a scheduler that gates the handshake correctly from one that counts everything it sees.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_BURST = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;

endpackage

// File: rtl/drs_cycle_timer.sv
// Free-running cycle counter that flags the last cycle of a LIMIT-long window.
module drs_cycle_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clear_i,
  output logic done_o
);

  generate
    if (LIMIT <= 1) begin : g_trivial
      assign done_o = en_i & ~clear_i;
    end else begin : g_count
      localparam int unsigned CW = $clog2(LIMIT);
      localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

      logic [CW-1:0] cnt_q;
      logic          at_last;

      assign at_last = (cnt_q == LAST);
      assign done_o  = en_i & ~clear_i & at_last;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
        end else if (clear_i) begin
          cnt_q <= '0;
        end else if (en_i) begin
          cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/drs_backlog.sv
// Owed-refresh counter, saturating at MAX_BACKLOG.
module drs_backlog #(
  parameter int unsigned MAX_BACKLOG = 8,
  localparam int unsigned CW = $clog2(MAX_BACKLOG + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          add_i,
  input  logic          take_i,
  output logic [CW-1:0] count_o
);

  localparam logic [CW-1:0] CAP = CW'(MAX_BACKLOG);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, empty;

  assign full  = (cnt_q == CAP);
  assign empty = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    unique case ({add_i, take_i})
      2'b10:   if (!full)  cnt_d = cnt_q + 1'b1;
      2'b01:   if (!empty) cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    if (clear_i) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/drs_phase_fsm.sv
// Pause -> wake-up burst -> run; watchdog expiry sends run back to burst.
module drs_phase_fsm
  import drs_pkg::*;
#(
  parameter int unsigned INIT_CYCLES = 8,
  localparam int unsigned BW = $clog2(INIT_CYCLES + 1)
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pause_done_i,
  input  logic   ack_i,
  input  logic   wdog_done_i,
  output phase_e phase_o
);

  localparam logic [BW-1:0] BURST_LEN = BW'(INIT_CYCLES);

  phase_e        phase_q, phase_d;
  logic [BW-1:0] left_q, left_d;

  always_comb begin
    phase_d = phase_q;
    left_d  = left_q;
    unique case (phase_q)
      PH_PAUSE: begin
        if (pause_done_i) begin
          phase_d = PH_BURST;
          left_d  = BURST_LEN;
        end
      end
      PH_BURST: begin
        if (ack_i) begin
          if (left_q <= BW'(1)) begin
            phase_d = PH_RUN;
            left_d  = '0;
          end else begin
            left_d = left_q - 1'b1;
          end
        end
      end
      PH_RUN: begin
        if (wdog_done_i) begin
          phase_d = PH_BURST;
          left_d  = BURST_LEN;
        end
      end
      default: begin
        phase_d = PH_PAUSE;
        left_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_PAUSE;
      left_q  <= '0;
    end else begin
      phase_q <= phase_d;
      left_q  <= left_d;
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import drs_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 100,
  parameter int unsigned PAUSE_US     = 500,
  parameter int unsigned RETENTION_US = 32000,
  parameter int unsigned ROWS         = 2048,
  parameter int unsigned INIT_CYCLES  = 8,
  parameter int unsigned MAX_BACKLOG  = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               ras_cycle_i,
  input  logic                               ref_ack_i,
  output logic                               ref_req_o,
  output logic                               init_o,
  output logic                               ready_o,
  output logic                               urgent_o,
  output logic [$clog2(MAX_BACKLOG+1)-1:0]   pending_o
);

  localparam int unsigned PAUSE_CLKS   = PAUSE_US * CLK_MHZ;
  localparam int unsigned WDOG_CLKS    = RETENTION_US * CLK_MHZ;
  localparam int unsigned REFRESH_CLKS = WDOG_CLKS / ROWS;
  localparam int unsigned PEND_W       = $clog2(MAX_BACKLOG + 1);

  phase_e              phase;
  logic                in_pause, in_burst, in_run;
  logic                pause_done, tick, wdog_done;
  logic                ack_ok, activity;
  logic [PEND_W-1:0]   pending;

  assign in_pause = (phase == PH_PAUSE);
  assign in_burst = (phase == PH_BURST);
  assign in_run   = (phase == PH_RUN);

  // handshake only counts while a request is visible
  assign ack_ok   = ref_ack_i & ref_req_o;
  assign activity = ras_cycle_i | ack_ok;

  drs_cycle_timer #(.LIMIT(PAUSE_CLKS)) u_pause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (in_pause),
    .clear_i (~in_pause),
    .done_o  (pause_done)
  );

  drs_cycle_timer #(.LIMIT(REFRESH_CLKS)) u_interval (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (in_run),
    .clear_i (~in_run),
    .done_o  (tick)
  );

  drs_cycle_timer #(.LIMIT(WDOG_CLKS)) u_wdog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (in_run),
    .clear_i (~in_run | activity),
    .done_o  (wdog_done)
  );

  drs_phase_fsm #(.INIT_CYCLES(INIT_CYCLES)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pause_done_i (pause_done),
    .ack_i        (ack_ok & in_burst),
    .wdog_done_i  (wdog_done),
    .phase_o      (phase)
  );

  drs_backlog #(.MAX_BACKLOG(MAX_BACKLOG)) u_backlog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (~in_run | wdog_done),
    .add_i   (tick),
    .take_i  (ack_ok & in_run),
    .count_o (pending)
  );

  assign ref_req_o = in_burst | (in_run & (pending != '0));
  assign init_o    = in_burst;
  assign ready_o   = in_run;
  assign urgent_o  = in_run & (pending > PEND_W'(1));
  assign pending_o = pending;

endmodule

// File: rtl/drs_sched_chk.sv
module drs_sched_chk #(
  parameter int unsigned MAX_BACKLOG = 8,
  localparam int unsigned PW = $clog2(MAX_BACKLOG + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ref_ack_i,
  input logic          ref_req_o,
  input logic          init_o,
  input logic          ready_o,
  input logic          urgent_o,
  input logic [PW-1:0] pending_o
);

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pending_o) <= int'(MAX_BACKLOG));

  a_r2_quiet_pause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !init_o) |-> (!ref_req_o && pending_o == '0));

  a_r3_burst_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(init_o && ready_o));

  a_r4_ready_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(init_o && ref_ack_i));

  a_r6_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(ready_o)) |->
      ((int'(pending_o) - int'($past(pending_o)) <= 1) &&
       (int'($past(pending_o)) - int'(pending_o) <= 1)));

  a_r6_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && !ref_ack_i && ready_o) |=> (ref_req_o || !ready_o));

  a_r8_urgent_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urgent_o |-> (ref_req_o && ready_o));

  a_r9_fall_reburst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> (init_o && pending_o == '0));

endmodule

bind dram_refresh_sched drs_sched_chk #(.MAX_BACKLOG(MAX_BACKLOG)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ref_ack_i (ref_ack_i),
  .ref_req_o (ref_req_o),
  .init_o    (init_o),
  .ready_o   (ready_o),
  .urgent_o  (urgent_o),
  .pending_o (pending_o)
);

// File: tb/dram_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb_top;

  localparam int CLK_MHZ = 1;
  localparam int PAUSE_US = 40;
  localparam int RET_US = 1000;
  localparam int ROWS = 32;
  localparam int INIT = 8;
  localparam int MAXB = 3;
  localparam int PCLK = PAUSE_US * CLK_MHZ;
  localparam int WCLK = RET_US * CLK_MHZ;
  localparam int ICLK = 31; // floor(1000/32)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_cycle_i = 1'b0;
  logic ref_ack_i = 1'b0;
  logic ref_req_o, init_o, ready_o, urgent_o;
  logic [1:0] pending_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit auto_ack = 0;

  always #5 clk = ~clk;

  dram_refresh_sched #(
    .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .RETENTION_US(RET_US),
    .ROWS(ROWS), .INIT_CYCLES(INIT), .MAX_BACKLOG(MAXB)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ras_cycle_i(ras_cycle_i), .ref_ack_i(ref_ack_i),
    .ref_req_o(ref_req_o), .init_o(init_o), .ready_o(ready_o),
    .urgent_o(urgent_o), .pending_o(pending_o)
  );

  // reference model: 0 pause, 1 burst, 2 run
  int m_mode, m_pc, m_left, m_tc, m_wc, m_pend;

  function automatic bit m_req();
    return (m_mode == 1) || (m_mode == 2 && m_pend > 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_pc = 0; m_left = 0; m_tc = 0; m_wc = 0; m_pend = 0;
    end else begin
      bit acc, act, tk;
      acc = ref_ack_i && m_req();
      act = ras_cycle_i || acc;
      case (m_mode)
        0: begin
          if (m_pc == PCLK - 1) begin m_mode = 1; m_left = INIT; m_pc = 0; end
          else m_pc++;
        end
        1: if (acc) begin
          if (m_left == 1) begin m_mode = 2; m_tc = 0; m_wc = 0; m_pend = 0; end
          else m_left--;
        end
        default: begin
          if (!act && m_wc == WCLK - 1) begin
            m_mode = 1; m_left = INIT; m_pend = 0; m_tc = 0; m_wc = 0;
          end else begin
            tk = (m_tc == ICLK - 1);
            m_tc = tk ? 0 : m_tc + 1;
            m_wc = act ? 0 : m_wc + 1;
            m_pend = m_pend + int'(tk) - int'(acc);
            if (m_pend > MAXB) m_pend = MAXB;
          end
        end
      endcase
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R4", "ready_o", int'(ready_o), int'(m_mode == 2));
      check("R3", "init_o", int'(init_o), int'(m_mode == 1));
      check("R6", "ref_req_o", int'(ref_req_o), int'(m_req()));
      check("R8", "urgent_o", int'(urgent_o), int'(m_mode == 2 && m_pend >= 2));
      check("R7", "pending_o", int'(pending_o), m_pend);
    end
  end

  task automatic run(input int n, input int ras_every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_ack_i   = auto_ack && ref_req_o;
      ras_cycle_i = (ras_every > 0) && (i % ras_every == 0);
    end
  endtask

  task automatic do_burst();
    // acknowledges on alternate cycles, with stray RAS pulses in between
    int got = 0;
    while (got < INIT) begin
      @(negedge clk);
      ref_ack_i = 1'b1; ras_cycle_i = 1'b0;
      @(negedge clk);
      got++;
      ref_ack_i = 1'b0; ras_cycle_i = 1'b1;
    end
    @(negedge clk);
    ras_cycle_i = 1'b0;
  endtask

  initial begin
    int n, t0, t1;
    bit stayed;
    repeat (3) @(negedge clk);
    check("R1", "ready_o in reset", int'(ready_o), 0);
    check("R1", "ref_req_o in reset", int'(ref_req_o), 0);
    check("R1", "init_o in reset", int'(init_o), 0);
    check("R1", "pending_o in reset", int'(pending_o), 0);
    rst_n = 1'b1;

    // R2: pause length, with stray acks and RAS pulses
    n = 0;
    do begin
      @(negedge clk);
      n++;
      ref_ack_i = (n % 3 == 0);
      ras_cycle_i = (n % 5 == 0);
    end while (!init_o && n < 10 * PCLK);
    ref_ack_i = 1'b0; ras_cycle_i = 1'b0;
    check("R2", "edges until init_o", n, PCLK);

    // R3/R4: wake-up burst
    do_burst();
    check("R4", "ready_o after burst", int'(ready_o), 1);

    // R5: spacing of refresh requests with prompt acks
    auto_ack = 1;
    n = 0;
    while (!ref_req_o) begin run(1, 0); n++; end
    t0 = n;
    while (ref_req_o) begin run(1, 0); n++; end
    while (!ref_req_o) begin run(1, 0); n++; end
    t1 = n;
    check("R5", "refresh spacing", t1 - t0, ICLK);
    run(4 * ICLK, 0);

    // R7/R8: stalled controller, watchdog kept alive by RAS pulses
    auto_ack = 0;
    run(6 * ICLK, 100);
    check("R7", "pending at cap", int'(pending_o), MAXB);
    check("R8", "urgent when backlog", int'(urgent_o), 1);

    // R6: drain, then acks with no request are ignored
    auto_ack = 1;
    while (ref_req_o) run(1, 0);
    auto_ack = 0;
    @(negedge clk);
    ref_ack_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R6", "pending after stray acks", int'(pending_o), 0);
    check("R6", "ref_req_o after stray acks", int'(ref_req_o), 0);
    ref_ack_i = 1'b0;

    // R9: idle controller trips the watchdog
    @(negedge clk); ras_cycle_i = 1'b1;
    @(negedge clk); ras_cycle_i = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (ready_o && n < 3 * WCLK);
    check("R9", "edges until ready_o falls", n, WCLK);
    check("R9", "init_o after expiry", int'(init_o), 1);
    check("R9", "pending after expiry", int'(pending_o), 0);
    do_burst();
    check("R9", "ready_o after re-burst", int'(ready_o), 1);

    // R10: RAS pulses alone keep ready_o up
    stayed = 1;
    for (int k = 0; k < 3 * WCLK; k++) begin
      @(negedge clk);
      ras_cycle_i = (k % (WCLK / 2) == 0);
      if (!ready_o) stayed = 0;
    end
    ras_cycle_i = 1'b0;
    check("R10", "ready_o held by RAS pulses", int'(stayed), 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule